// File: doc/BRIEF.md
# Bridge Target-Abort Propagation Logic

This block sits between the initiating-side and target-side halves of a PCI-to-PCI bridge. It samples the target-bus termination signals (STOP#, TRDY#, DEVSEL#) in each data phase and sorts the phase into one of these classes: a plain transfer, a disconnect with data, a disconnect without data, a retry or a target-abort. It also tracks the progress of the current transaction on each bus. From the phase class and the transaction progress it decides what to drive back toward the initiator. It sets sticky abort bits in a primary and a secondary status register, and it pulses the primary system-error output.

Bus signals appear at the ports as active-high "asserted" flags. Pad inversion is done outside the block. On the initiating side a transaction is either non-posted, posted and still running, disconnected early by the bridge, or posted and already finished. The reaction to a target-abort depends on which of these holds. If the initiator is still attached, the abort is mirrored in the same cycle. If the bridge has already disconnected a non-posted initiator, the abort is only recorded. If a posted write has already finished on the initiating side, the block raises a system error.

Top module: `tab_abort_relay`

## Requirements
- R1: A data phase is valid only while a target transaction is open (the cycle after `tgt_frame_i` is seen from idle, until a stop-class phase or bus idle), `tgt_irdy_i` is 1 and `tgt_stop_i` or `tgt_trdy_i` is 1. A valid phase with stop=0, trdy=1 and devsel=1 reports `tgt_phase_o`=1. Any other non-stop or invalid phase reports 0.
- R2: A valid phase with stop=1, trdy=1 and devsel=1 reports `tgt_phase_o`=2 (disconnect, this word transfers and is the last).
- R3: A valid phase with stop=1, trdy=0 and devsel=1 reports 3 (disconnect, the previous word was the last) if an earlier phase of the same transaction reported 1. Otherwise it reports 5 (retry).
- R4: A valid phase with stop=1 and devsel=0 reports 4 (target-abort) whatever trdy is. After any phase reporting 2, 3, 4 or 5, the block reports 0 until the target bus has gone idle and a new transaction has opened.
- R5: While the initiating transaction is non-posted and attached, an abort phase drives `ini_stop_o`=1, `ini_trdy_o`=0 and `ini_devsel_o`=0 in the same cycle. Any other non-zero phase class has its raw stop/trdy/devsel values forwarded to those outputs in the same cycle.
- R6: While a posted write is still running on the initiating bus, an abort phase is mirrored in the same cycle as in R5. Non-abort phases drive all three initiator outputs to 0, as they do in every other state.
- R7: On the clock edge that ends an abort phase, the status register of the target-side bus sets bit 1 (abort received). The initiating-side register sets bit 0 (abort signalled) only if the abort was mirrored. With `dir_i`=0 the initiating bus is primary (`pri_sts_o`). With `dir_i`=1 it is secondary. All status bits are 0 after reset.
- R8: After `ini_disc_i` during a non-posted transaction, a later abort is not mirrored and the abort-signalled bit stays 0. The abort-received bit is still set.
- R9: After a posted write has finished on the initiating bus (the bus went idle or the bridge disconnected it), an abort is not mirrored. The abort-received bit is set, and `serr_no` goes low for exactly one clock after the abort edge, only if `serr_en_i` and `perr_en_i` are both 1. `serr_no` is 1 after reset.
- R10: A status bit stays set until a 1 is written to its bit of `pri_clr_i` or `sec_clr_i`. A set and a clear in the same cycle leave the bit set.
- R11: A non-posted or disconnected initiating transaction returns to idle when `ini_frame_i` and `ini_irdy_i` are both 0. A finished posted write returns to idle when the target bus is idle. An abort seen while the initiating side is idle is not mirrored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | 0: initiator on primary bus, 1: initiator on secondary bus |
| serr_en_i | input | 1 | System-error reporting enable |
| perr_en_i | input | 1 | Error-response enable |
| ini_frame_i | input | 1 | Initiating bus FRAME# asserted |
| ini_irdy_i | input | 1 | Initiating bus IRDY# asserted |
| ini_start_i | input | 1 | Pulse: bridge accepted a new transaction |
| ini_posted_i | input | 1 | Qualifies `ini_start_i`: transaction is a posted write |
| ini_disc_i | input | 1 | Pulse: bridge disconnected the initiator |
| tgt_frame_i | input | 1 | Target bus FRAME# asserted |
| tgt_irdy_i | input | 1 | Target bus IRDY# asserted |
| tgt_stop_i | input | 1 | Target bus STOP# asserted |
| tgt_trdy_i | input | 1 | Target bus TRDY# asserted |
| tgt_devsel_i | input | 1 | Target bus DEVSEL# asserted |
| pri_clr_i | input | 2 | Write-one-to-clear strobes, primary status |
| sec_clr_i | input | 2 | Write-one-to-clear strobes, secondary status |
| ini_stop_o | output | 1 | STOP# toward the initiator, asserted high |
| ini_trdy_o | output | 1 | TRDY# toward the initiator, asserted high |
| ini_devsel_o | output | 1 | DEVSEL# toward the initiator, asserted high |
| tgt_phase_o | output | 3 | Current phase class (0 none, 1 transfer, 2 disconnect with data, 3 disconnect without data, 4 abort, 5 retry) |
| pri_sts_o | output | 2 | Primary status: bit 0 abort signalled, bit 1 abort received |
| sec_sts_o | output | 2 | Secondary status, same layout |
| serr_no | output | 1 | System error, active low, one-clock pulse |

## Verification
The block has no size parameter: the status width is fixed at two bits per bus, so the bench builds the single default configuration. That makes a full sweep affordable. The sweep crosses all eight stop/trdy/devsel combinations with and without a prior transfer, all four initiating-side progress states, both bus directions, all four enable pairs, and clearing with or without a same-cycle set. This covers every classification, every mirror or suppress decision and every status mapping. Directed sequences then cover the idle-return rules and partial clearing.

// File: rtl/tab_pkg.sv
package tab_pkg;
  localparam int STS_W   = 2;
  localparam int NUM_BUS = 2;
  localparam int STS_SIG = 0;  // abort signalled to initiator
  localparam int STS_RCV = 1;  // abort received from target

  typedef enum logic [2:0] {
    PH_NONE        = 3'd0,
    PH_XFER        = 3'd1,
    PH_DISC_DATA   = 3'd2,
    PH_DISC_NODATA = 3'd3,
    PH_ABORT       = 3'd4,
    PH_RETRY       = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    TS_IDLE,
    TS_OPEN,
    TS_MOVED,
    TS_ENDED
  } tgt_st_e;

  typedef enum logic [2:0] {
    IS_IDLE,
    IS_ACTIVE,
    IS_POSTED,
    IS_DISC,
    IS_DONE
  } ini_st_e;
endpackage

// File: rtl/tab_phase_sort.sv
module tab_phase_sort
  import tab_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   frame_i,
  input  logic   irdy_i,
  input  logic   stop_i,
  input  logic   trdy_i,
  input  logic   devsel_i,
  output phase_e phase_o,
  output logic   idle_o
);
  tgt_st_e st_q, st_d;
  phase_e  phase;
  logic    open_w, valid_w, stop_cls;

  assign idle_o = !frame_i && !irdy_i;
  assign open_w = (st_q == TS_OPEN) || (st_q == TS_MOVED);
  assign valid_w = open_w && irdy_i && (stop_i || trdy_i);

  always_comb begin
    phase = PH_NONE;
    if (valid_w) begin
      if (stop_i && !devsel_i)  phase = PH_ABORT;
      else if (stop_i && trdy_i) phase = PH_DISC_DATA;
      else if (stop_i)           phase = (st_q == TS_MOVED) ? PH_DISC_NODATA : PH_RETRY;
      else if (devsel_i)         phase = PH_XFER;
    end
  end

  assign stop_cls = (phase == PH_DISC_DATA) || (phase == PH_DISC_NODATA) ||
                    (phase == PH_ABORT) || (phase == PH_RETRY);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TS_IDLE: if (frame_i) st_d = TS_OPEN;
      TS_OPEN, TS_MOVED: begin
        if (stop_cls)               st_d = TS_ENDED;
        else if (phase == PH_XFER)  st_d = TS_MOVED;
        else if (idle_o)            st_d = TS_IDLE;
      end
      TS_ENDED: if (idle_o) st_d = TS_IDLE;
      default: st_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= TS_IDLE;
    else         st_q <= st_d;
  end

  assign phase_o = phase;

  // R4: one terminating phase per transaction
  p_one_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_cls |=> (phase_o == PH_NONE));

  // R3: no-data disconnect only after a transfer in the same transaction
  p_nodata_after_xfer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PH_DISC_NODATA) |-> (st_q == TS_MOVED) && $past(st_q != TS_IDLE));
endmodule

// File: rtl/tab_ini_track.sv
module tab_ini_track
  import tab_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    posted_i,
  input  logic    disc_i,
  input  logic    bus_idle_i,
  input  logic    tgt_idle_i,
  output ini_st_e state_o
);
  ini_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      IS_IDLE:   if (start_i) st_d = posted_i ? IS_POSTED : IS_ACTIVE;
      IS_ACTIVE: begin
        if (disc_i)          st_d = IS_DISC;
        else if (bus_idle_i) st_d = IS_IDLE;
      end
      IS_POSTED: if (disc_i || bus_idle_i) st_d = IS_DONE;
      IS_DISC:   if (bus_idle_i) st_d = IS_IDLE;
      IS_DONE:   if (tgt_idle_i) st_d = IS_IDLE;
      default:   st_d = IS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= IS_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  // R9: finished state only reached through a posted write
  p_done_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == IS_DONE) |-> ($past(st_q) == IS_POSTED) || ($past(st_q) == IS_DONE));

  // R8: disconnected state only reached from a non-posted transaction
  p_disc_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == IS_DISC) |-> ($past(st_q) == IS_ACTIVE) || ($past(st_q) == IS_DISC));
endmodule

// File: rtl/tab_sticky.sv
module tab_sticky #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (q_q & ~clr_i) | set_i;  // set wins
  end

  assign q_o = q_q;

  // R10: uncleared bits persist
  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((q_o & ~clr_i) != '0) |=> ((q_o & $past(q_o & ~clr_i)) == $past(q_o & ~clr_i)));

  // R10: a bit only rises from a set request
  p_set_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((q_o & ~$past(q_o)) != '0) |-> ((q_o & ~$past(q_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/tab_abort_relay.sv
module tab_abort_relay
  import tab_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_i,
  input  logic             serr_en_i,
  input  logic             perr_en_i,
  input  logic             ini_frame_i,
  input  logic             ini_irdy_i,
  input  logic             ini_start_i,
  input  logic             ini_posted_i,
  input  logic             ini_disc_i,
  input  logic             tgt_frame_i,
  input  logic             tgt_irdy_i,
  input  logic             tgt_stop_i,
  input  logic             tgt_trdy_i,
  input  logic             tgt_devsel_i,
  input  logic [STS_W-1:0] pri_clr_i,
  input  logic [STS_W-1:0] sec_clr_i,
  output logic             ini_stop_o,
  output logic             ini_trdy_o,
  output logic             ini_devsel_o,
  output logic [2:0]       tgt_phase_o,
  output logic [STS_W-1:0] pri_sts_o,
  output logic [STS_W-1:0] sec_sts_o,
  output logic             serr_no
);
  phase_e  phase;
  ini_st_e ini_st;
  logic    tgt_idle, ini_idle;
  logic    is_abort, mirror, fwd, serr_req, serr_q;

  logic [NUM_BUS-1:0][STS_W-1:0] set_w, clr_w, q_w;

  assign ini_idle = !ini_frame_i && !ini_irdy_i;

  tab_phase_sort u_sort (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_i  (tgt_frame_i),
    .irdy_i   (tgt_irdy_i),
    .stop_i   (tgt_stop_i),
    .trdy_i   (tgt_trdy_i),
    .devsel_i (tgt_devsel_i),
    .phase_o  (phase),
    .idle_o   (tgt_idle)
  );

  tab_ini_track u_ini (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (ini_start_i),
    .posted_i   (ini_posted_i),
    .disc_i     (ini_disc_i),
    .bus_idle_i (ini_idle),
    .tgt_idle_i (tgt_idle),
    .state_o    (ini_st)
  );

  assign is_abort = (phase == PH_ABORT);
  // initiator still attached: return the abort in this data phase
  assign mirror   = is_abort && ((ini_st == IS_ACTIVE) || (ini_st == IS_POSTED));
  assign fwd      = (ini_st == IS_ACTIVE) && (phase != PH_NONE) && !is_abort;
  assign serr_req = is_abort && (ini_st == IS_DONE) && serr_en_i && perr_en_i;

  always_comb begin
    ini_stop_o   = 1'b0;
    ini_trdy_o   = 1'b0;
    ini_devsel_o = 1'b0;
    if (mirror) begin
      ini_stop_o = 1'b1;
    end else if (fwd) begin
      ini_stop_o   = tgt_stop_i;
      ini_trdy_o   = tgt_trdy_i;
      ini_devsel_o = tgt_devsel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) serr_q <= 1'b1;
    else         serr_q <= !serr_req;
  end
  assign serr_no = serr_q;

  assign clr_w[0] = pri_clr_i;
  assign clr_w[1] = sec_clr_i;

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus
    logic ini_side;
    assign ini_side = (dir_i == 1'(g));
    always_comb begin
      set_w[g]          = '0;
      set_w[g][STS_SIG] = mirror && ini_side;
      set_w[g][STS_RCV] = is_abort && !ini_side;
    end
    tab_sticky #(.W(STS_W)) u_sts (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_w[g]),
      .clr_i  (clr_w[g]),
      .q_o    (q_w[g])
    );
  end

  assign pri_sts_o   = q_w[0];
  assign sec_sts_o   = q_w[1];
  assign tgt_phase_o = phase;

  // R5: same-cycle abort mirror while the initiator is attached
  p_mirror_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_abort && (ini_st == IS_ACTIVE || ini_st == IS_POSTED))
      |-> (ini_stop_o && !ini_trdy_o && !ini_devsel_o));

  // R6: outside the non-posted state only a mirrored abort drives the initiator
  p_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ini_st != IS_ACTIVE) && !(is_abort && ini_st == IS_POSTED))
      |-> !(ini_stop_o || ini_trdy_o || ini_devsel_o));

  // R9: system error lasts one clock
  p_serr_one_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_no |=> serr_no);

  // R9: system error needs both enables and a finished posted write
  p_serr_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_no |-> $past(serr_en_i && perr_en_i && ini_st == IS_DONE && is_abort));
endmodule

// File: tb/tb_tab_abort_relay.sv
module tb_tab_abort_relay;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dir_i = 0, serr_en_i = 0, perr_en_i = 0;
  logic ini_frame_i = 0, ini_irdy_i = 0, ini_start_i = 0, ini_posted_i = 0, ini_disc_i = 0;
  logic tgt_frame_i = 0, tgt_irdy_i = 0, tgt_stop_i = 0, tgt_trdy_i = 0, tgt_devsel_i = 0;
  logic [1:0] pri_clr_i = 0, sec_clr_i = 0;
  logic ini_stop_o, ini_trdy_o, ini_devsel_o, serr_no;
  logic [2:0] tgt_phase_o;
  logic [1:0] pri_sts_o, sec_sts_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tab_abort_relay dut (
    .clk_i(clk), .rst_ni(rst_ni), .dir_i(dir_i), .serr_en_i(serr_en_i), .perr_en_i(perr_en_i),
    .ini_frame_i(ini_frame_i), .ini_irdy_i(ini_irdy_i), .ini_start_i(ini_start_i),
    .ini_posted_i(ini_posted_i), .ini_disc_i(ini_disc_i),
    .tgt_frame_i(tgt_frame_i), .tgt_irdy_i(tgt_irdy_i), .tgt_stop_i(tgt_stop_i),
    .tgt_trdy_i(tgt_trdy_i), .tgt_devsel_i(tgt_devsel_i),
    .pri_clr_i(pri_clr_i), .sec_clr_i(sec_clr_i),
    .ini_stop_o(ini_stop_o), .ini_trdy_o(ini_trdy_o), .ini_devsel_o(ini_devsel_o),
    .tgt_phase_o(tgt_phase_o), .pri_sts_o(pri_sts_o), .sec_sts_o(sec_sts_o), .serr_no(serr_no)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic go_idle();
    ini_frame_i = 0; ini_irdy_i = 0; ini_start_i = 0; ini_disc_i = 0;
    tgt_frame_i = 0; tgt_irdy_i = 0; tgt_stop_i = 0; tgt_trdy_i = 0; tgt_devsel_i = 0;
    pri_clr_i = 0; sec_clr_i = 0;
    repeat (3) tick();
  endtask

  // expected phase class from R1..R4
  function automatic int exp_class(bit s, bit t, bit d, bit seen);
    if (!(s || t)) return 0;
    if (s && !d) return 4;
    if (s && t) return 2;
    if (s) return seen ? 3 : 5;
    if (d) return 1;
    return 0;
  endfunction

  // mode: 0 non-posted, 1 posted running, 2 disconnected, 3 posted finished
  task automatic scenario(input int mode, input bit seen, input bit s, input bit t, input bit d,
                          input bit dr, input bit se, input bit pe, input bit clr_c);
    int cls, o_exp, pri_e, sec_e;
    bit ab, mir;
    cls = exp_class(s, t, d, seen);
    ab  = (cls == 4);
    mir = ab && (mode <= 1);
    if (mir)                            o_exp = 4;
    else if (mode == 0 && cls != 0)     o_exp = {29'd0, s, t, d};
    else                                o_exp = 0;
    pri_e = dr ? {30'd0, ab, 1'b0} : {31'd0, mir};
    sec_e = dr ? {31'd0, mir} : {30'd0, ab, 1'b0};
    // A
    tick();
    dir_i = dr; serr_en_i = se; perr_en_i = pe;
    pri_clr_i = 2'b11; sec_clr_i = 2'b11;
    ini_frame_i = 1; ini_irdy_i = 1; ini_start_i = 1; ini_posted_i = (mode == 1 || mode == 3);
    tgt_frame_i = 1;
    // B
    tick();
    pri_clr_i = 0; sec_clr_i = 0; ini_start_i = 0;
    if (mode == 2) ini_disc_i = 1;
    if (mode == 3) begin ini_frame_i = 0; ini_irdy_i = 0; end
    if (seen) begin tgt_irdy_i = 1; tgt_trdy_i = 1; tgt_devsel_i = 1; tgt_stop_i = 0; end
    // C
    tick();
    ini_disc_i = 0;
    tgt_irdy_i = 1; tgt_stop_i = s; tgt_trdy_i = t; tgt_devsel_i = d;
    if (clr_c) begin pri_clr_i = 2'b11; sec_clr_i = 2'b11; end
    @(negedge clk);
    chk(cls == 1 ? "R1 transfer" : cls == 2 ? "R2 disc data" : cls == 3 ? "R3 disc nodata" :
        cls == 4 ? "R4 abort" : cls == 5 ? "R3 retry" : "R1 none", tgt_phase_o, cls);
    chk(mode == 0 ? "R5 initiator drive" : mode == 1 ? "R6 posted drive" :
        mode == 2 ? "R8 disc no mirror" : "R9 done no mirror",
        {ini_stop_o, ini_trdy_o, ini_devsel_o}, o_exp);
    // D: hold the same pins
    tick();
    pri_clr_i = 0; sec_clr_i = 0;
    @(negedge clk);
    chk(clr_c ? "R10 set wins pri" : (mode == 2 ? "R8 pri status" : "R7 pri status"), pri_sts_o, pri_e);
    chk(clr_c ? "R10 set wins sec" : (mode == 3 ? "R9 sec status" : "R7 sec status"), sec_sts_o, sec_e);
    chk("R9 serr pulse", serr_no, !(ab && mode == 3 && se && pe));
    chk("R4 after stop", tgt_phase_o, (cls >= 2) ? 0 : cls);
    // E
    tick();
    tgt_irdy_i = 0; tgt_stop_i = 0; tgt_trdy_i = 0; tgt_devsel_i = 0;
    pri_clr_i = 2'b11;
    @(negedge clk);
    chk("R9 serr one clock", serr_no, 1);
    chk("R10 sticky pri", pri_sts_o, pri_e);
    // F
    tick();
    pri_clr_i = 0;
    @(negedge clk);
    chk("R10 cleared pri", pri_sts_o, 0);
    chk("R10 untouched sec", sec_sts_o, sec_e);
    go_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk);
    chk("R7 reset pri", pri_sts_o, 0);
    chk("R7 reset sec", sec_sts_o, 0);
    chk("R9 reset serr", serr_no, 1);
    chk("R1 reset phase", tgt_phase_o, 0);
    chk("R5 reset drive", {ini_stop_o, ini_trdy_o, ini_devsel_o}, 0);

    for (int m = 0; m < 4; m++)
      for (int sn = 0; sn < 2; sn++)
        for (int c = 0; c < 8; c++)
          for (int dr = 0; dr < 2; dr++)
            for (int en = 0; en < 4; en++)
              for (int cc = 0; cc < 2; cc++)
                scenario(m, sn[0], c[2], c[1], c[0], dr[0], en[1], en[0], cc[0]);

    // R11: non-posted initiator goes idle before the target aborts
    tick();
    dir_i = 0; serr_en_i = 1; perr_en_i = 1;
    ini_frame_i = 1; ini_irdy_i = 1; ini_start_i = 1; ini_posted_i = 0; tgt_frame_i = 1;
    tick();
    ini_start_i = 0; ini_frame_i = 0; ini_irdy_i = 0;
    tick();
    tgt_irdy_i = 1; tgt_stop_i = 1; tgt_trdy_i = 0; tgt_devsel_i = 0;
    @(negedge clk);
    chk("R11 idle phase", tgt_phase_o, 4);
    chk("R11 idle no mirror", {ini_stop_o, ini_trdy_o, ini_devsel_o}, 0);
    tick();
    tgt_irdy_i = 0; tgt_stop_i = 0;
    @(negedge clk);
    chk("R11 idle pri", pri_sts_o, 0);
    chk("R11 idle sec", sec_sts_o, 2);
    chk("R11 idle serr", serr_no, 1);
    sec_clr_i = 2'b11;
    go_idle();

    // R11: finished posted write waits for the target bus to go idle
    tick();
    ini_frame_i = 1; ini_irdy_i = 1; ini_start_i = 1; ini_posted_i = 1; tgt_frame_i = 1;
    tick();
    ini_start_i = 0; ini_frame_i = 0; ini_irdy_i = 0;
    tick();
    tgt_frame_i = 0;
    tick();
    tick();
    tgt_frame_i = 1;
    tick();
    tgt_frame_i = 1;
    tick();
    tgt_irdy_i = 1; tgt_stop_i = 1; tgt_devsel_i = 0;
    @(negedge clk);
    tick();
    tgt_irdy_i = 0; tgt_stop_i = 0;
    @(negedge clk);
    chk("R11 posted back to idle serr", serr_no, 1);
    chk("R11 posted back to idle pri", pri_sts_o, 0);
    go_idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule